// File: doc/BRIEF.md
# Periodic Update Pulse Generator

This block produces the update strobe that moves staged configuration from holding registers into the live datapath of a frequency synthesizer. In internal mode a 32-bit down-counter runs on an enable that fires every second system clock. Each time the counter expires, the block emits a one-cycle update strobe. The same event drives a fixed eight-cycle pulse onto a bidirectional pad, so that external logic can align its writes with the update rhythm.

In external mode the pad output driver is released and the pad becomes an input. Its rising edges pass through a two-flop synchronizer and an edge detector before they produce the same one-cycle strobe. This keeps a strobe from landing while register data is still settling, which would otherwise transfer a mix of old and new values. The mode input is registered inside the block, and that register resets to internal mode.

Top module: `upd_pulse_gen`

## Requirements
- R1: While `rst` is high, `update_o` and `pin_o` are 0 and `pin_oe_o` is 1 (internal mode), whatever `int_mode_i` is.
- R2: In internal mode the counter starts at zero after reset. The first strobe is seen on `update_o` in the cycle after the second rising clock edge following reset release.
- R3: In internal mode, with a programmed count N of 1 or more, consecutive strobes are exactly 2·(N+1) clock cycles apart.
- R4: `update_o` is high for one clock cycle per event and is never high in two consecutive cycles.
- R5: In internal mode `pin_o` goes high in the same cycle as each strobe and stays high for 8 cycles. A new strobe arriving inside that window restarts the 8 cycles, so with N ≤ 3 the pin stays high without a break.
- R6: The value on `period_i` is sampled in the cycle a strobe is issued, and that value sets the length of the following interval. A change made after the sampling cycle first affects the interval after the next strobe.
- R7: `pin_oe_o` equals the value `int_mode_i` had one clock earlier (1 = internal, 0 = external). `pin_o` is 0 whenever `pin_oe_o` is 0.
- R8: In external mode, suppose `pin_i` is sampled 0 at one clock edge and 1 at the next edge k. Then `update_o` is high for one cycle, in the cycle after edge k+2. Falling edges and steady levels produce no strobe.
- R9: In internal mode `pin_i` has no effect on `update_o` or `pin_o`. In external mode the counter produces no strobes.
- R10: When `int_mode_i` goes from 0 to 1, the counter restarts from zero. The first strobe appears in the cycle after the third rising edge following the change, and later strobes follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 32 | Programmed count N (interval is 2·(N+1) cycles) |
| int_mode_i | input | 1 | 1 = internal periodic mode, 0 = external edge mode |
| pin_i | input | 1 | Pad input level (used in external mode) |
| pin_o | output | 1 | Pad output level (eight-cycle pulse in internal mode) |
| pin_oe_o | output | 1 | Pad output enable, high in internal mode |
| update_o | output | 1 | One-cycle transfer strobe |

## Verification
Two functions can fall in the same cycle, and the bench provokes each of them.

The first pair is the end of one pad pulse and the strobe that starts the next one. With N set to 1, 2, 3 and 4, strobes land inside the pulse window, on its last cycle, or just after it. The bench judges the pad level against a model that restarts the eight-cycle window at each expected strobe.

The second pair is the period reload and a change of `period_i`. The bench changes the period in the same cycle a strobe is observed and requires the next gap to keep the old length and all later gaps to take the new one.

Random pad toggling is applied in both modes, so that ignored and honoured edges are both exercised.

// File: rtl/upd_pkg.sv
package upd_pkg;

    typedef enum logic {
        UPD_EXT = 1'b0,
        UPD_INT = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic strobe;
        logic pin;
        logic oe;
    } upd_out_t;

    function automatic int upd_cnt_w(input int len);
        return $clog2(len + 1);
    endfunction

    function automatic longint upd_interval(input longint n);
        return 2 * (n + 1);
    endfunction

endpackage

// File: rtl/upd_half_tick.sv
module upd_half_tick (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) half_q <= 1'b0;
        else               half_q <= ~half_q;
    end

    assign tick_o = run_i & half_q;
endmodule

// File: rtl/upd_down_cnt.sv
module upd_down_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign fire_o  = run_i & tick_i & at_zero;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (at_zero) cnt_q <= period_i;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/upd_edge_sync.sv
module upd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/upd_pulse_stretch.sv
module upd_pulse_stretch #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic trig_i,
    output logic active_o
);
    localparam int PW = upd_pkg::upd_cnt_w(LEN);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)      left_q <= '0;
        else if (trig_i)        left_q <= PW'(LEN);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/upd_pulse_gen.sv
module upd_pulse_gen #(
    parameter int CNT_W       = 32,
    parameter int PULSE_CYC   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic             int_mode_i,
    input  logic             pin_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             update_o
);
    import upd_pkg::*;

    upd_mode_e mode_q;
    logic      internal;
    logic      tick;
    logic      fire;
    logic      rise;
    logic      stretch_on;
    logic      strobe_q;
    upd_out_t  out_s;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= UPD_INT;
        else     mode_q <= upd_mode_e'(int_mode_i);
    end

    assign internal = (mode_q == UPD_INT);

    upd_half_tick u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (internal),
        .tick_o (tick)
    );

    upd_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run_i    (internal),
        .tick_i   (tick),
        .period_i (period_i),
        .fire_o   (fire)
    );

    upd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (pin_i),
        .rise_o (rise)
    );

    upd_pulse_stretch #(.LEN(PULSE_CYC)) u_stretch (
        .clk      (clk),
        .rst      (rst),
        .run_i    (internal),
        .trig_i   (fire),
        .active_o (stretch_on)
    );

    always_ff @(posedge clk) begin
        if (rst)           strobe_q <= 1'b0;
        else if (internal) strobe_q <= fire;
        else               strobe_q <= rise;
    end

    assign out_s.strobe = strobe_q;
    assign out_s.pin    = stretch_on & internal;
    assign out_s.oe     = internal;

    assign update_o = out_s.strobe;
    assign pin_o    = out_s.pin;
    assign pin_oe_o = out_s.oe;
endmodule

// File: rtl/upd_pulse_gen_chk.sv
module upd_pulse_gen_chk #(
    parameter int PULSE_CYC = 8
) (
    input logic clk,
    input logic rst,
    input logic int_mode_i,
    input logic pin_i,
    input logic pin_o,
    input logic pin_oe_o,
    input logic update_o
);
    localparam int SW = $clog2(PULSE_CYC + 1);

    logic [SW-1:0] since_q;
    logic [2:0]    age_q;

    always_ff @(posedge clk) begin
        if (rst || !pin_oe_o)          since_q <= SW'(PULSE_CYC);
        else if (update_o)             since_q <= SW'(1);
        else if (since_q < SW'(PULSE_CYC)) since_q <= since_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)               age_q <= '0;
        else if (age_q != 3'd7) age_q <= age_q + 1'b1;
    end

    assert_oe_tracks_mode_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pin_oe_o == $past(int_mode_i)));

    assert_pin_needs_oe_R7: assert property (@(posedge clk) disable iff (rst)
        !pin_oe_o |-> !pin_o);

    assert_pulse_starts_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(pin_o) && pin_oe_o) |-> update_o);

    assert_pulse_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o && since_q < SW'(PULSE_CYC)) |-> pin_o);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        (update_o && pin_oe_o) |=> !update_o);

    assert_ext_edge_source_R8: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd5 && update_o && !$past(pin_oe_o)) |-> ($past(pin_i, 3) && !$past(pin_i, 4)));
endmodule

bind upd_pulse_gen upd_pulse_gen_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .int_mode_i (int_mode_i),
    .pin_i      (pin_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .update_o   (update_o)
);

// File: tb/upd_pulse_gen_tb.sv
module upd_pulse_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] period_i;
    logic        int_mode_i;
    logic        pin_i;
    logic        pin_o;
    logic        pin_oe_o;
    logic        update_o;

    int n_checks = 0;
    int n_errs   = 0;
    int n_cur;
    logic dm1, dm2, rh1, rh2;

    always #5 clk = ~clk;

    upd_pulse_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .int_mode_i (int_mode_i),
        .pin_i      (pin_i),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o),
        .update_o   (update_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    function automatic int interval(input int n);
        return 2 * (n + 1);
    endfunction

    task automatic wait_update();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (update_o) return;
        end
        chk(1'b0, "R3", "strobe never seen", 32'd0, 32'd1);
    endtask

    // i=0 is the negedge where a strobe that loaded n1 was seen
    task automatic watch(input int n1, input int n2, input int cycles, input bit noise);
        int p1 = interval(n1);
        int p2 = interval(n2);
        int last = 0;
        bit eu;
        bit ep;
        for (int i = 1; i <= cycles; i++) begin
            @(negedge clk);
            eu = (i >= p1) && (((i - p1) % p2) == 0);
            if (eu) last = i;
            ep = (i - last) < 8;
            chk(update_o == eu, "R3 R4 R6", "strobe", 32'(update_o), 32'(eu));
            chk(pin_o == ep, "R5", "pad pulse", 32'(pin_o), 32'(ep));
            chk(pin_oe_o == 1'b1, "R7", "oe internal", 32'(pin_oe_o), 32'd1);
            if (noise) pin_i = 1'($urandom % 2);  // R9: pad input ignored
        end
    endtask

    task automatic ext_run(input int cycles, input logic [31:0] pat, input string req);
        logic r_now;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            r_now = dm1 & ~dm2;
            chk(update_o == rh2, req, "external strobe", 32'(update_o), 32'(rh2));
            chk(pin_oe_o == 1'b0 && pin_o == 1'b0, "R7", "pad released", {pin_oe_o, pin_o}, 32'd0);
            rh2 = rh1;
            rh1 = r_now;
            dm2 = dm1;
            dm1 = pat[i];
            pin_i = pat[i];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        int nn;
        void'($urandom(32'd7321));
        rst = 1'b1;
        period_i = 32'd5;
        int_mode_i = 1'b0;
        pin_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset forces internal mode and quiet outputs
        chk(pin_oe_o == 1'b1, "R1", "oe in reset", 32'(pin_oe_o), 32'd1);
        chk(update_o == 1'b0, "R1", "strobe in reset", 32'(update_o), 32'd0);
        chk(pin_o == 1'b0, "R1", "pad in reset", 32'(pin_o), 32'd0);
        int_mode_i = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        chk(update_o == 1'b0, "R2", "no strobe after first edge", 32'(update_o), 32'd0);
        @(negedge clk);
        chk(update_o == 1'b1, "R2", "first strobe", 32'(update_o), 32'd1);
        n_cur = 5;
        watch(5, 5, interval(5) * 4 + 1, 1'b1);
        pin_i = 1'b0;

        // R5 directed: pulse windows touching, overlapping and just separated
        for (int d = 1; d <= 4; d++) begin
            wait_update();
            period_i = 32'(d);
            watch(n_cur, d, interval(n_cur) + 4 * interval(d) + 1, 1'b0);
            n_cur = d;
        end

        // R6 random period changes on the strobe cycle
        for (int t = 0; t < 8; t++) begin
            nn = 1 + int'($urandom % 20);
            wait_update();
            period_i = 32'(nn);
            watch(n_cur, nn, interval(n_cur) + 3 * interval(nn) + 1, 1'b1);
            n_cur = nn;
        end
        pin_i = 1'b0;
        repeat (4) @(negedge clk);

        // switch to external right after a strobe
        period_i = 32'd30;
        wait_update();
        wait_update();
        n_cur = 30;
        int_mode_i = 1'b0;
        @(negedge clk);
        chk(pin_oe_o == 1'b0, "R7", "oe released", 32'(pin_oe_o), 32'd0);
        dm1 = 1'b0; dm2 = 1'b0; rh1 = 1'b0; rh2 = 1'b0;
        ext_run(32, 32'h0, "R9");             // no counter strobes in external mode
        ext_run(12, 32'h0000_0002, "R8");     // one-cycle pad pulse
        ext_run(12, 32'hFFFF_FFF0, "R8");     // rise then hold
        ext_run(12, 32'h0, "R8");             // falling edge: no strobe
        for (int t = 0; t < 8; t++) ext_run(32, $urandom, "R8");
        ext_run(8, 32'h0, "R8");

        // R10: return to internal mode
        period_i = 32'd6;
        int_mode_i = 1'b1;
        @(negedge clk);
        chk(pin_oe_o == 1'b1, "R7", "oe back", 32'(pin_oe_o), 32'd1);
        chk(update_o == 1'b0, "R10", "no strobe edge 1", 32'(update_o), 32'd0);
        @(negedge clk);
        chk(update_o == 1'b0, "R10", "no strobe edge 2", 32'(update_o), 32'd0);
        @(negedge clk);
        chk(update_o == 1'b1, "R10", "restart strobe", 32'(update_o), 32'd1);
        chk(pin_o == 1'b1, "R10", "restart pad", 32'(pin_o), 32'd1);
        watch(6, 6, interval(6) * 3 + 1, 1'b1);
        finish_run();
    end
endmodule